// File: doc/BRIEF.md
# Asynchronous Button Event Catcher

This block sits between raw push-button lines and a synchronous controller. It catches every rising edge on each button line, including a press so short that it starts and ends between two clock edges. Each caught press becomes a single-cycle strobe in the system clock domain. The controller reads these strobes on its own clock edge and never has its state changed directly by a button.

Each button has its own capture element. It is clocked by the button line itself and flips a toggle on every rising edge. The toggle crosses into the clock domain through a multi-stage synchronizer. A clock-domain copy of the last toggle value seen acts as the clear: once a change has been taken, it no longer counts as pending. Because the capture element is never cleared from the clock domain, a press that lands while the previous one is being consumed still flips the toggle and is not lost. After each accepted press, a lockout counter drops further edges for a set number of cycles, which rejects contact bounce. A debounced copy of each button's level is also provided. The channels share nothing but the clock and reset.

Top module: `btn_event_catcher`

## Requirements
- R1: While `rst_i` is high (active high, asynchronous), every bit of `evt_o` and `lvl_o` is 0. A press caught just before reset produces no strobe after reset is released.
- R2: A rising edge on a button line produces a strobe even when the line goes high and back low within less than one clock period, at any phase relative to the clock.
- R3: A strobe on `evt_o[i]` is high for exactly one clock cycle. When the button rises between two clock edges, the strobe is high in the cycle that follows the third rising clock edge after the button edge.
- R4: A press held for many cycles produces exactly one strobe, and its release produces none.
- R5: With `LOCK_CYC` > 0, rising edges that reach the clock domain during the `LOCK_CYC` cycles after an accepted strobe are dropped. With the default of 16, bounce edges arriving up to 10 cycles after a press add no strobe.
- R6: A press that arrives after the lockout has expired (20 or more cycles after the previous strobe, with the default setting) produces a new strobe.
- R7: The channels are independent. A press on one channel never produces a strobe on another. Presses on several channels in the same instant produce strobes on all of them in the same cycle.
- R8: `lvl_o[i]` follows the synchronized level of button i, but only updates while that channel's lockout is idle. It holds its value while the lockout runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| btn_i | input | N_CH | Raw button lines, active high, asynchronous to `clk_i` |
| evt_o | output | N_CH | One-cycle press strobes, one bit per channel |
| lvl_o | output | N_CH | Debounced button levels, one bit per channel |

## Verification
The bench sweeps half-nanosecond button pulses across every phase of the clock period. A design that only sampled the button level would miss most of these pulses and report too few strobes. The exact cycle of the strobe is checked, so an extra or missing synchronizer stage shows up as a latency mismatch. Widely spaced bounce edges and presses just inside and just outside the lockout test the filter: a missing lockout gives extra strobes, and a lockout that never ends loses the later press. Simultaneous and single-channel presses catch crosstalk between channels. Held and released levels, and a reset that lands while a press is still in flight, check the level output and the reset behaviour.

// File: rtl/bec_pkg.sv
package bec_pkg;
  // One channel's signals after synchronization
  typedef struct packed {
    logic tog;
    logic lvl;
  } bec_chan_t;

  localparam int unsigned BEC_SYNC_STAGES = 2;
endpackage

// File: rtl/bec_edge_catch.sv
// Capture element clocked by the button itself: flips on every rising edge.
module bec_edge_catch (
  input  logic btn_i,
  input  logic rst_i,
  output logic tog_o
);
  always_ff @(posedge btn_i or posedge rst_i) begin
    if (rst_i) tog_o <= 1'b0;
    else       tog_o <= ~tog_o;
  end
endmodule

// File: rtl/bec_sync.sv
// Multi-stage synchronizer into the clock domain
module bec_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)       stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bec_filter.sv
// Consumes toggle changes, issues strobes, applies lockout, tracks level
module bec_filter #(
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tog_s_i,
  input  logic lvl_s_i,
  output logic evt_o,
  output logic lvl_o
);
  localparam int unsigned CW = (LOCK_CYC > 0) ? $clog2(LOCK_CYC + 1) : 1;

  logic seen_q;
  logic busy;
  logic take;

  assign take = (tog_s_i != seen_q) && !busy;

  if (LOCK_CYC > 0) begin : g_lock
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)              cnt_q <= '0;
      else if (take)          cnt_q <= CW'(LOCK_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
    assign busy = (cnt_q != '0);

    AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_o |=> !evt_o); // R3
  end else begin : g_nolock
    assign busy = 1'b0;
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      seen_q <= 1'b0;
      evt_o  <= 1'b0;
      lvl_o  <= 1'b0;
    end else begin
      seen_q <= tog_s_i;   // consuming the change is the clear
      evt_o  <= take;
      if (!busy) lvl_o <= lvl_s_i;
    end
  end

  AST_LOCK_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    busy |=> !evt_o); // R5
  AST_LVL_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    busy |=> $stable(lvl_o)); // R8
endmodule

// File: rtl/btn_event_catcher.sv
module btn_event_catcher #(
  parameter int unsigned N_CH     = 2,
  parameter int unsigned LOCK_CYC = 16
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [N_CH-1:0] btn_i,
  output logic [N_CH-1:0] evt_o,
  output logic [N_CH-1:0] lvl_o
);
  import bec_pkg::*;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic      tog_raw;
    bec_chan_t raw_c;
    bec_chan_t syn_c;

    bec_edge_catch i_catch (
      .btn_i (btn_i[c]),
      .rst_i (rst_i),
      .tog_o (tog_raw)
    );

    assign raw_c.tog = tog_raw;
    assign raw_c.lvl = btn_i[c];

    bec_sync #(.WIDTH($bits(bec_chan_t)), .STAGES(BEC_SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (raw_c),
      .q_o   (syn_c)
    );

    bec_filter #(.LOCK_CYC(LOCK_CYC)) i_filt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .tog_s_i (syn_c.tog),
      .lvl_s_i (syn_c.lvl),
      .evt_o   (evt_o[c]),
      .lvl_o   (lvl_o[c])
    );
  end

  AST_RST_QUIET: assert property (@(posedge clk_i)
    rst_i |-> (evt_o == '0 && lvl_o == '0)); // R1
endmodule

// File: tb/test_btn_event_catcher.sv
`timescale 1ns/100ps
module test_btn_event_catcher;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] btn = 2'b00;
  logic [1:0] evt;
  logic [1:0] lvl;
  int n_chk = 0, n_bad = 0;
  int cnt0 = 0, cnt1 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  btn_event_catcher #(.N_CH(2), .LOCK_CYC(16)) i_btn_event_catcher (
    .clk_i(clk), .rst_i(rst), .btn_i(btn), .evt_o(evt), .lvl_o(lvl));

  always @(negedge clk) if (!rst) begin
    cnt0 += int'(evt[0]);
    cnt1 += int'(evt[1]);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(logic [1:0] m, real w);
    btn = btn | m;
    #(w);
    btn = btn & ~m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int b0, b1;
    cycles(5);
    #1;
    check("R1 reset evt", int'(evt), 0);
    check("R1 reset lvl", int'(lvl), 0);
    @(negedge clk); rst = 1'b0;
    cycles(5);

    // R3 exact latency for a sub-period pulse (R2)
    @(negedge clk); #1;
    pulse(2'b01, 2.0);
    cycles(3); #1;
    check("R3 strobe cycle", int'(evt[0]), 1);
    check("R7 other channel quiet", int'(evt[1]), 0);
    @(posedge clk); #1;
    check("R3 strobe one cycle", int'(evt[0]), 0);
    cycles(30);
    check("R2 narrow pulse count", cnt0, 1);

    // R2 phase sweep with 0.5 ns pulses
    for (int k = 1; k < 8; k++) begin
      if (k == 4) continue;
      b0 = cnt0;
      @(negedge clk); #(k);
      pulse(2'b01, 0.5);
      cycles(30);
      check($sformatf("R2 phase %0d", k), cnt0 - b0, 1);
    end

    // R4 long press
    b0 = cnt0;
    btn[0] = 1'b1; cycles(60);
    btn[0] = 1'b0; cycles(40);
    check("R4 long press single strobe", cnt0 - b0, 1);

    // R5 bounce: three rises spaced ~1.6 cycles
    b0 = cnt0;
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      pulse(2'b01, 5.0);
      #8;
    end
    cycles(40);
    check("R5 bounce rejected", cnt0 - b0, 1);

    // R5 second press 10 cycles later is dropped
    b0 = cnt0;
    @(negedge clk); pulse(2'b01, 3.0);
    cycles(10);
    @(negedge clk); pulse(2'b01, 3.0);
    cycles(40);
    check("R5 press inside lockout", cnt0 - b0, 1);

    // R6 second press 25 cycles later is taken
    b0 = cnt0;
    @(negedge clk); pulse(2'b01, 3.0);
    cycles(25);
    @(negedge clk); pulse(2'b01, 3.0);
    cycles(40);
    check("R6 press after lockout", cnt0 - b0, 2);

    // R7 simultaneous presses
    b0 = cnt0; b1 = cnt1;
    @(negedge clk); #1;
    pulse(2'b11, 1.0);
    cycles(3); #1;
    check("R7 both strobes same cycle", int'(evt), 3);
    cycles(30);
    check("R7 ch0 count", cnt0 - b0, 1);
    check("R7 ch1 count", cnt1 - b1, 1);

    // R7 single channel 1 press leaves channel 0 untouched
    b0 = cnt0; b1 = cnt1;
    @(negedge clk); pulse(2'b10, 2.0);
    cycles(30);
    check("R7 ch1 alone", cnt1 - b1, 1);
    check("R7 ch0 untouched", cnt0 - b0, 0);

    // R8 debounced level
    @(negedge clk); btn[0] = 1'b1;
    cycles(40); #1;
    check("R8 level high", int'(lvl), 1);
    @(negedge clk); btn[0] = 1'b0;
    cycles(40); #1;
    check("R8 level low", int'(lvl), 0);

    // R1 reset while a press is in flight
    b0 = cnt0;
    @(negedge clk); pulse(2'b01, 2.0);
    @(posedge clk); #1;
    rst = 1'b1;
    cycles(2); #1;
    check("R1 evt during reset", int'(evt), 0);
    @(negedge clk); rst = 1'b0;
    cycles(30);
    check("R1 press dropped by reset", cnt0 - b0, 0);

    finish_run();
  end
endmodule